// File: doc/BRIEF.md
# Performance Monitoring Counter Unit

This block counts hardware events for one processor core. It has four programmable counters and three dedicated counters. Each programmable counter has its own event-select register. That register picks one of the event inputs, filters by the privilege level of the code that is running, and can arm an overflow interrupt. The dedicated counters track retired instructions, unhalted core cycles and unhalted reference cycles. All three share one control register, with a four-bit field each.

A global enable register, a global overflow status register and an overflow-clear register each act on every counter in a single access. Software can write the counters to clear them or to preload them. Sampling works by preloading a counter to its wrap value minus N, so that the overflow, and the interrupt if armed, follows after N events.

A separate index port returns any counter value. Bit 30 of the index selects the dedicated counters. The interrupt output is a level: it stays high while an armed overflow flag is set.

Top module: `perf_count_unit`

## Requirements
- R1: After reset every counter, event-select, fixed control, global control and status register reads 0, and `irq` is 0.
- R2: Programmable counter i (event-select at address 0x00+i, counter at 0x10+i) increments by one on each clock edge where all of the following hold: the input `evtIn[code]` is high, where code is event-select bits 7:0; event-select bit 22 (count enable) is set; global-control bit i is set; and the privilege filter passes.
- R3: A counter holds its value when either its global-control bit or its local enable is clear, even while its event is active.
- R4: Privilege filter: when `privUser`=1 a programmable counter needs event-select bit 16 set, and when `privUser`=0 it needs bit 17 set. For a dedicated counter, bit 1 of its field serves user mode and bit 0 serves kernel mode.
- R5: Dedicated counter j (counter at 0x20+j) counts `fixEvt[j]`. It uses field bits 4j+3:4j of the fixed control register (0x30) and global-control bit 32+j.
- R6: When an enabled counter increments from all ones, it wraps to 0 and keeps counting. On that same edge, status bit i (programmable) or 32+j (dedicated) is set in the global status register (0x32).
- R7: Writing a mask to the overflow-clear register (0x33) clears the status bits that are set in the mask and leaves the others. A wrap in the same cycle wins over the clear.
- R8: `irq` is high exactly while some status bit is set whose counter has its interrupt enabled. The enable is event-select bit 20 for a programmable counter and field bit 3 for a dedicated counter.
- R9: `cntIdxData` shows, one cycle after `cntIdx`, the following: programmable counter N when bit 30 is clear and N<4; dedicated counter k when bit 30 is set and bits 29:0 equal k<3; otherwise 0. It is also 0 when bit 31 is set.
- R10: A register read returns the data on `regRdata` one cycle after `regRd`. A write to a counter loads it and takes priority over an increment in the same cycle.
- R11: Writing zero to an event-select register stops that counter from the next cycle. The counter keeps its value.
- R12: An event code of `NUM_EVT` or more never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 8 | Register address |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data, one cycle after `regRd` |
| cntIdx | input | 32 | Counter index for the read-by-index port |
| cntIdxData | output | 64 | Counter value selected by `cntIdx`, one cycle later |
| evtIn | input | NUM_EVT | Event inputs for the programmable counters |
| fixEvt | input | 3 | Events for the dedicated counters |
| privUser | input | 1 | 1 = user mode, 0 = kernel mode |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the unit with `CNT_W`=16 and `NUM_EVT`=4. A 16-bit counter can be preloaded near its wrap value, so overflow, the status flags, the race between a wrap and a clear, and the interrupt all occur within a few cycles. With only four event inputs, an event code of 5 is out of range, which exercises the case where no event is selected. Expected values come from counting event cycles by hand against the privilege and enable settings.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;
  // Counter counts follow the register layout: global bits 0..3 and 32..34
  localparam int NUM_GP        = 4;
  localparam int NUM_FIX       = 3;
  localparam int NUM_CNT       = NUM_GP + NUM_FIX;
  localparam int DATA_W        = 64;
  localparam int ADDR_W        = 8;
  localparam int FIX_STAT_BASE = 32;

  // event-select bit positions
  localparam int ES_USR = 16;
  localparam int ES_OS  = 17;
  localparam int ES_INT = 20;
  localparam int ES_EN  = 22;

  // fixed control field layout
  localparam int FF_W   = 4;
  localparam int FF_OS  = 0;
  localparam int FF_USR = 1;
  localparam int FF_INT = 3;

  // address map
  localparam logic [ADDR_W-1:0] A_EVSEL = 8'h00;
  localparam logic [ADDR_W-1:0] A_GPCNT = 8'h10;
  localparam logic [ADDR_W-1:0] A_FXCNT = 8'h20;
  localparam logic [ADDR_W-1:0] A_FXCTL = 8'h30;
  localparam logic [ADDR_W-1:0] A_GCTL  = 8'h31;
  localparam logic [ADDR_W-1:0] A_GSTAT = 8'h32;
  localparam logic [ADDR_W-1:0] A_OVCLR = 8'h33;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_CNT-1:0] load;
    logic [NUM_CNT-1:0] step;
  } dpCmd_t;
endpackage

// File: rtl/pcu_datapath.sv
`timescale 1ns/1ps
module pcu_datapath
  import pcu_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dpCmd_t                            cmd,
  input  logic [CNT_W-1:0]                  loadVal,
  output logic [NUM_CNT-1:0][CNT_W-1:0]     cntVal,
  output logic [NUM_CNT-1:0]                wrapHit
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            cnt[k] <= '0;
      else if (cmd.load[k]) cnt[k] <= loadVal;
      else if (cmd.step[k]) cnt[k] <= cnt[k] + 1'b1;
    end

    assign wrapHit[k] = cmd.step[k] && !cmd.load[k] && (cnt[k] == ALL_ONES);

    // R10: a load lands regardless of a same-cycle step
    a_r10_load: assert property (@(posedge clk) disable iff (!rstN)
      cmd.load[k] |=> (cnt[k] == $past(loadVal)));
    // R6: a step from all ones lands on zero
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rstN)
      (cmd.step[k] && !cmd.load[k] && cnt[k] == ALL_ONES) |=> (cnt[k] == '0));
    // R3: no strobe, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!cmd.step[k] && !cmd.load[k]) |=> $stable(cnt[k]));
  end

  assign cntVal = cnt;
endmodule

// File: rtl/pcu_ctrl.sv
`timescale 1ns/1ps
module pcu_ctrl
  import pcu_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int NUM_EVT = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWr,
  input  logic                          regRd,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]             regWdata,
  output logic [DATA_W-1:0]             regRdata,
  input  logic [31:0]                   cntIdx,
  output logic [DATA_W-1:0]             cntIdxData,
  input  logic [NUM_EVT-1:0]            evtIn,
  input  logic [NUM_FIX-1:0]            fixEvt,
  input  logic                          privUser,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  input  logic [NUM_CNT-1:0]            wrapHit,
  output dpCmd_t                        cmd,
  output logic [CNT_W-1:0]              loadVal,
  output logic                          irq
);
  localparam int EVT_IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [NUM_GP-1:0][DATA_W-1:0] evSel;
  logic [DATA_W-1:0] fixCtl, gCtl, gStat;
  logic [DATA_W-1:0] statNext, setMask, clrMask, irqMask;
  logic [DATA_W-1:0] rdNext, idxNext;
  logic [NUM_GP-1:0] wrEvSel;
  logic wrFix, wrGctl, wrClr;

  function automatic logic [DATA_W-1:0] zext(input logic [CNT_W-1:0] c);
    zext = '0;
    zext[CNT_W-1:0] = c;
  endfunction

  // write decode
  always_comb begin
    for (int i = 0; i < NUM_GP; i++)
      wrEvSel[i] = regWr && (regAddr == A_EVSEL + 8'(i));
    wrFix  = regWr && (regAddr == A_FXCTL);
    wrGctl = regWr && (regAddr == A_GCTL);
    wrClr  = regWr && (regAddr == A_OVCLR);
  end

  // counter strobes
  always_comb begin
    for (int i = 0; i < NUM_GP; i++) begin
      logic [7:0] code;
      logic hit, privOk;
      code   = evSel[i][7:0];
      hit    = (int'(code) < NUM_EVT) && evtIn[code[EVT_IDX_W-1:0]];
      privOk = privUser ? evSel[i][ES_USR] : evSel[i][ES_OS];
      cmd.step[i] = gCtl[i] && evSel[i][ES_EN] && privOk && hit;
      cmd.load[i] = regWr && (regAddr == A_GPCNT + 8'(i));
    end
    for (int j = 0; j < NUM_FIX; j++) begin
      logic [FF_W-1:0] fld;
      logic privOk;
      fld    = fixCtl[FF_W*j +: FF_W];
      privOk = privUser ? fld[FF_USR] : fld[FF_OS];
      cmd.step[NUM_GP+j] = gCtl[FIX_STAT_BASE+j] && privOk && fixEvt[j];
      cmd.load[NUM_GP+j] = regWr && (regAddr == A_FXCNT + 8'(j));
    end
  end

  assign loadVal = regWdata[CNT_W-1:0];

  // overflow status and interrupt masks
  always_comb begin
    setMask = '0;
    irqMask = '0;
    for (int i = 0; i < NUM_GP; i++) begin
      setMask[i] = wrapHit[i];
      irqMask[i] = evSel[i][ES_INT];
    end
    for (int j = 0; j < NUM_FIX; j++) begin
      setMask[FIX_STAT_BASE+j] = wrapHit[NUM_GP+j];
      irqMask[FIX_STAT_BASE+j] = fixCtl[FF_W*j+FF_INT];
    end
    clrMask  = wrClr ? regWdata : '0;
    statNext = (gStat & ~clrMask) | setMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evSel  <= '0;
      fixCtl <= '0;
      gCtl   <= '0;
      gStat  <= '0;
    end else begin
      for (int i = 0; i < NUM_GP; i++)
        if (wrEvSel[i]) evSel[i] <= regWdata;
      if (wrFix)  fixCtl <= regWdata;
      if (wrGctl) gCtl   <= regWdata;
      gStat <= statNext;
    end
  end

  assign irq = |(gStat & irqMask);

  // register read mux
  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_GP; i++) begin
      if (regAddr == A_EVSEL + 8'(i)) rdNext = evSel[i];
      if (regAddr == A_GPCNT + 8'(i)) rdNext = zext(cntVal[i]);
    end
    for (int j = 0; j < NUM_FIX; j++)
      if (regAddr == A_FXCNT + 8'(j)) rdNext = zext(cntVal[NUM_GP+j]);
    if (regAddr == A_FXCTL) rdNext = fixCtl;
    if (regAddr == A_GCTL)  rdNext = gCtl;
    if (regAddr == A_GSTAT) rdNext = gStat;
  end

  // read-by-index mux
  always_comb begin
    idxNext = '0;
    if (!cntIdx[31]) begin
      if (cntIdx[30]) begin
        for (int j = 0; j < NUM_FIX; j++)
          if (cntIdx[29:0] == 30'(j)) idxNext = zext(cntVal[NUM_GP+j]);
      end else begin
        for (int i = 0; i < NUM_GP; i++)
          if (cntIdx[29:0] == 30'(i)) idxNext = zext(cntVal[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdata   <= '0;
      cntIdxData <= '0;
    end else begin
      if (regRd) regRdata <= rdNext;
      cntIdxData <= idxNext;
    end
  end

  // R7: with no wrap in flight, cleared bits are gone next cycle
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrClr && wrapHit == '0) |=> ((gStat & $past(regWdata)) == '0));

  // R8: with nothing flagged the interrupt stays low
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (gStat == '0) |-> !irq);

  for (genvar i = 0; i < NUM_GP; i++) begin : g_gpchk
    // R6: a wrap flags its status bit
    a_r6_stat: assert property (@(posedge clk) disable iff (!rstN)
      wrapHit[i] |=> gStat[i]);
    // R11: a zero event-select stops counting next cycle
    a_r11_stop: assert property (@(posedge clk) disable iff (!rstN)
      (regWr && regAddr == A_EVSEL + 8'(i) && regWdata == '0) |=> !cmd.step[i]);
  end

  for (genvar j = 0; j < NUM_FIX; j++) begin : g_fxchk
    // R6: dedicated wrap flags bit 32+j
    a_r6_fstat: assert property (@(posedge clk) disable iff (!rstN)
      wrapHit[NUM_GP+j] |=> gStat[FIX_STAT_BASE+j]);
  end
endmodule

// File: rtl/perf_count_unit.sv
`timescale 1ns/1ps
module perf_count_unit
  import pcu_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [7:0]         regAddr,
  input  logic [63:0]        regWdata,
  output logic [63:0]        regRdata,
  input  logic [31:0]        cntIdx,
  output logic [63:0]        cntIdxData,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [2:0]         fixEvt,
  input  logic               privUser,
  output logic               irq
);
  dpCmd_t                        cmd;
  logic [CNT_W-1:0]              loadVal;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;
  logic [NUM_CNT-1:0]            wrapHit;

  pcu_ctrl #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cntIdx(cntIdx),
    .cntIdxData(cntIdxData), .evtIn(evtIn), .fixEvt(fixEvt),
    .privUser(privUser), .cntVal(cntVal), .wrapHit(wrapHit), .cmd(cmd),
    .loadVal(loadVal), .irq(irq)
  );

  pcu_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadVal(loadVal),
    .cntVal(cntVal), .wrapHit(wrapHit)
  );
endmodule

// File: tb/sim_perf_count_unit.sv
`timescale 1ns/1ps
module sim_perf_count_unit;
  localparam int CW = 16;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0, idxChk = 1'b0;
  logic [7:0] regAddr = '0;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata, cntIdxData;
  logic [31:0] cntIdx = '0;
  logic [NE-1:0] evtIn = '0;
  logic [2:0] fixEvt = '0;
  logic privUser = 1'b0;
  logic irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [63:0] expQ[$];
  string tagQ[$];

  perf_count_unit #(.CNT_W(CW), .NUM_EVT(NE)) u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cntIdx(cntIdx),
    .cntIdxData(cntIdxData), .evtIn(evtIn), .fixEvt(fixEvt),
    .privUser(privUser), .irq(irq)
  );

  always #2.5 clk = ~clk;

  localparam logic [7:0] EVS = 8'h00, GPC = 8'h10, FXC = 8'h20, FXCTL = 8'h30,
                         GCTL = 8'h31, GSTAT = 8'h32, OVCLR = 8'h33;
  localparam logic [63:0] GALL = 64'h0000_0007_0000_000F;

  // monitor: pop expected items as results appear
  initial forever begin
    @(posedge clk);
    if (regRd || idxChk) begin
      logic [63:0] act, exp;
      string tag;
      bit fromIdx;
      fromIdx = idxChk;
      #1;
      act = fromIdx ? cntIdxData : regRdata;
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      vectors++;
      if (act !== exp) begin
        miscompares++;
        $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [63:0] d,
                    input logic [NE-1:0] e = '0);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d; evtIn = e;
    @(negedge clk);
    regWr = 1'b0; evtIn = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic idx(input logic [31:0] i, input logic [63:0] exp, input string tag);
    @(negedge clk);
    idxChk = 1'b1; cntIdx = i;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    idxChk = 1'b0;
  endtask

  task automatic pulse(input logic [NE-1:0] e, input logic [2:0] f, input int n);
    @(negedge clk);
    evtIn = e; fixEvt = f;
    repeat (n) @(negedge clk);
    evtIn = '0; fixEvt = '0;
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    @(negedge clk);
    vectors++;
    if (irq !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic setPriv(input logic p);
    @(negedge clk);
    privUser = p;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(EVS, 64'h0, "R1 evsel0");
    rd(GPC, 64'h0, "R1 gp0");
    rd(FXCTL, 64'h0, "R1 fixctl");
    rd(GCTL, 64'h0, "R1 gctl");
    rd(GSTAT, 64'h0, "R1 status");
    chkIrq(1'b0, "R1 irq");

    // R2 basic counting
    wr(GCTL, GALL);
    wr(EVS + 0, 64'h0043_0002);
    wr(EVS + 1, 64'h0003_0001);
    pulse(4'b0110, 3'b000, 5);
    rd(GPC + 0, 64'd5, "R2 gp0 counts code 2");
    rd(GPC + 1, 64'd0, "R3 gp1 local enable off");
    rd(EVS + 0, 64'h0043_0002, "R10 evsel0 readback");

    // R3 global bit off
    wr(GCTL, 64'h0000_0007_0000_000E);
    pulse(4'b0100, 3'b000, 3);
    rd(GPC + 0, 64'd5, "R3 gp0 global off");
    wr(GCTL, GALL);

    // R4 privilege filter
    wr(EVS + 2, 64'h0041_0003);
    pulse(4'b1000, 3'b000, 3);
    rd(GPC + 2, 64'd0, "R4 gp2 kernel filtered");
    setPriv(1'b1);
    pulse(4'b1000, 3'b000, 2);
    rd(GPC + 2, 64'd2, "R4 gp2 user counted");
    setPriv(1'b0);

    // R11 zero event-select stops counting
    wr(EVS + 0, 64'h0);
    pulse(4'b0100, 3'b000, 3);
    rd(GPC + 0, 64'd5, "R11 gp0 held after zero select");

    // R12 out-of-range code
    wr(EVS + 3, 64'h0043_0005);
    pulse(4'b1111, 3'b000, 4);
    rd(GPC + 3, 64'd0, "R12 gp3 code 5");

    // R5 dedicated counters
    wr(FXCTL, 64'h023);
    pulse(4'b0000, 3'b111, 4);
    setPriv(1'b1);
    pulse(4'b0000, 3'b111, 2);
    setPriv(1'b0);
    rd(FXC + 0, 64'd6, "R5 fix0 both levels");
    rd(FXC + 1, 64'd2, "R5 fix1 user only");
    rd(FXC + 2, 64'd0, "R5 fix2 disabled");

    // R9 read by index
    idx(32'h4000_0000, 64'd6, "R9 idx fix0");
    idx(32'h4000_0001, 64'd2, "R9 idx fix1");
    idx(32'h4000_0002, 64'd0, "R9 idx fix2");
    idx(32'h4000_0003, 64'd0, "R9 idx fixed out of range");
    idx(32'h0000_0000, 64'd5, "R9 idx gp0");
    idx(32'h0000_0002, 64'd2, "R9 idx gp2");
    idx(32'h0000_0007, 64'd0, "R9 idx gp out of range");
    idx(32'h8000_0000, 64'd0, "R9 idx bit31 set");

    // R6 overflow of a programmable counter, R8 interrupt
    wr(EVS + 3, 64'h0053_0000);
    wr(GPC + 3, 64'hFFFE);
    pulse(4'b0001, 3'b000, 3);
    rd(GPC + 3, 64'd1, "R6 gp3 wrapped and continued");
    rd(GSTAT, 64'h8, "R6 status bit3");
    chkIrq(1'b1, "R8 irq armed gp3");

    // R7 clear by mask
    wr(OVCLR, 64'h4);
    rd(GSTAT, 64'h8, "R7 other bit kept");
    chkIrq(1'b1, "R8 irq still high");
    wr(OVCLR, 64'hF);
    rd(GSTAT, 64'h0, "R7 cleared");
    chkIrq(1'b0, "R8 irq dropped");

    // R7 wrap wins over same-cycle clear
    wr(GPC + 3, 64'hFFFF);
    wr(OVCLR, 64'h8, 4'b0001);
    rd(GSTAT, 64'h8, "R7 set beats clear");
    wr(OVCLR, 64'h8);
    rd(GSTAT, 64'h0, "R7 cleared after race");

    // R6 dedicated overflow, R8 field interrupt bit
    wr(FXC + 0, 64'hFFFF);
    pulse(4'b0000, 3'b001, 1);
    rd(FXC + 0, 64'd0, "R6 fix0 wrapped");
    rd(GSTAT, 64'h1_0000_0000, "R6 status bit32");
    chkIrq(1'b0, "R8 not armed");
    wr(FXCTL, 64'h02B);
    chkIrq(1'b1, "R8 armed fix0");
    wr(OVCLR, 64'h1_0000_0000);
    rd(GSTAT, 64'h0, "R7 fixed flag cleared");
    chkIrq(1'b0, "R8 irq low after clear");

    // R10 load beats same-cycle increment
    wr(GPC + 3, 64'h100, 4'b0001);
    rd(GPC + 3, 64'h100, "R10 load priority");
    rd(GCTL, GALL, "R10 gctl readback");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule